// File: doc/BRIEF.md
# Two-Channel Debug Break Comparator

This block watches the bus cycles of a processor and asks for a debug break when a cycle meets a programmed condition. It has two channels, A and B. Each channel compares a 40-bit value made of an 8-bit address-space tag and a 32-bit address, using a mask bit for each address bit. It can also require a given cycle type, transfer direction and operand size. Channel B can also compare the data, through a 32-bit mask. Each channel chooses which of two bus ports it monitors. Channel B can take its data from either port.

The channels can raise breaks on their own (independent mode), or as a chain in which A must be seen before B on a later cycle (sequential mode). A repeat count makes channel B fire only on its Nth qualifying match. On instruction fetches, a per-channel bit delays the break until an instruction-complete strobe arrives. The output is a one-cycle break request plus two sticky status flags, one per channel. Debugger software clears these flags by writing zero.

Top module: `brk_unit`

## Requirements
- R1: An address bit takes part in the compare only when its mask bit is 0. A mask bit of 1 makes that address bit don't-care.
- R2: The address-space tag in bits [7:0] of the tag register must equal the cycle's tag, unless bit 8 of that register is 1, which ignores the tag completely.
- R3: Control bit 1 picks the monitored port: 0 selects port 0 and 1 selects port 1. Cycles on the other port never match.
- R4: Control qualifiers. Bits [3:2] set the cycle type: 01 means fetch only, 10 means data only, and 00 or 11 mean either. Bits [5:4] set the direction: 01 means read, 10 means write, and 00 or 11 mean either. Bits [7:6] set the size: 01 is byte, 10 is word, 11 is longword and 00 is any, where the bus size code is 00 byte, 01 word, 10 longword.
- R5: Channel B also needs (data XOR value) AND NOT data-mask to be zero. Control bit 9 picks the data source: 0 takes port 0 data and 1 takes port 1 data.
- R6: In independent mode (mode bit 0 = 0), a match of channel A, or a completed match of channel B, raises brk_req for exactly one cycle. This happens on the clock edge that ends the matching cycle, and the matching channel's status flag is set.
- R7: In sequential mode (mode bit 0 = 1), a break comes only when channel B matches on a cycle after a channel A match. A cycle in which both match does not complete the sequence. A completed sequence clears the record of A.
- R8: The mode register field [2:1] holds a count N. Channel B completes on every Nth qualifying match; N = 0 acts as 1.
- R9: When control bit 8 is 1 and the match is a fetch, the request waits until the next ret_vld pulse and is issued on the edge that samples that pulse. Otherwise the request is immediate.
- R10: A write to the status register (offset 11) clears flag A when wdata bit 0 is 0 and flag B when wdata bit 1 is 0. A bit written as 1 leaves its flag unchanged.
- R11: Any write to a register other than status clears the sequential record of A and the repeat count.
- R12: After reset, all registers are zero, both channels are disabled (control bit 0 = 0), and brk_req and both flags are low.

Register offsets: 0, 1, 2 and 3 are the address, address mask, tag and control registers of channel A. 4, 5, 6 and 7 are the same registers for channel B. 8 is the B data value, 9 is the B data mask, 10 is the mode register and 11 is the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| bus0_vld | input | 1 | Port 0 cycle valid |
| bus0_asid | input | 8 | Port 0 address-space tag |
| bus0_addr | input | 32 | Port 0 address |
| bus0_data | input | 32 | Port 0 data |
| bus0_fetch | input | 1 | Port 0 cycle is an instruction fetch |
| bus0_wr | input | 1 | Port 0 cycle is a write |
| bus0_size | input | 2 | Port 0 size code |
| bus1_vld | input | 1 | Port 1 cycle valid |
| bus1_asid | input | 8 | Port 1 address-space tag |
| bus1_addr | input | 32 | Port 1 address |
| bus1_data | input | 32 | Port 1 data |
| bus1_fetch | input | 1 | Port 1 cycle is an instruction fetch |
| bus1_wr | input | 1 | Port 1 cycle is a write |
| bus1_size | input | 2 | Port 1 size code |
| ret_vld | input | 1 | Instruction-complete strobe |
| brk_req | output | 1 | One-cycle break request |
| stat_a | output | 1 | Sticky channel A flag |
| stat_b | output | 1 | Sticky channel B flag |

## Verification
The assertions check on every cycle that the following rules hold:
- every request has a cause in the previous cycle;
- sequential completion never occurs while A is unrecorded;
- the repeat count stays below its limit;
- flags do not drop without a status write;
- a held request waits for the strobe;
- a condition write clears the chain state.

Only the bench scenarios can show the following behaviours, because they compare outputs against values computed from the register settings:
- which addresses, tags, qualifiers and data values match;
- the order rules of sequential mode;
- the count at which channel B fires;
- the clearing of flags selected by the written bits.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int AW  = 32;
    localparam int IW  = 8;
    localparam int DW  = 32;
    localparam int RAW = 4;
    localparam int NCH = 2;

    localparam logic [RAW-1:0] OFS_ADDR  = 4'd0;
    localparam logic [RAW-1:0] OFS_AMASK = 4'd1;
    localparam logic [RAW-1:0] OFS_TAG   = 4'd2;
    localparam logic [RAW-1:0] OFS_CTRL  = 4'd3;
    localparam int             CH_STRIDE = 4;
    localparam logic [RAW-1:0] RG_BDATA  = 4'd8;
    localparam logic [RAW-1:0] RG_BDMASK = 4'd9;
    localparam logic [RAW-1:0] RG_MODE   = 4'd10;
    localparam logic [RAW-1:0] RG_STAT   = 4'd11;

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] asid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          fetch;
        logic          write;
        logic [1:0]    size;
    } bus_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] amask;
        logic [IW-1:0] asid;
        logic          asid_ign;
        logic          en;
        logic          bus_sel;
        logic [1:0]    ctype;
        logic [1:0]    dir;
        logic [1:0]    size;
        logic          after;
        logic          dbus_sel;
        logic [DW-1:0] data;
        logic [DW-1:0] dmask;
    } cfg_t;

    function automatic logic ctype_ok(input logic [1:0] sel, input logic fetch);
        case (sel)
            2'b01:   return fetch;
            2'b10:   return !fetch;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic dir_ok(input logic [1:0] sel, input logic write);
        case (sel)
            2'b01:   return !write;
            2'b10:   return write;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic size_ok(input logic [1:0] sel, input logic [1:0] sz);
        if (sel == 2'b00) return 1'b1;
        return sel == (sz + 2'd1);
    endfunction
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int REP_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RAW-1:0]       addr,
    input  logic [31:0]          wdata,
    output cfg_t [NCH-1:0]       cfg,
    output logic                 seq_mode,
    output logic [REP_W-1:0]     rep_n,
    output logic                 cond_wr,
    output logic                 stat_wr
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [RAW-1:0] BASE = RAW'(ch * CH_STRIDE);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[ch] <= '0;
            end else if (we) begin
                if (addr == BASE + OFS_ADDR)  cfg[ch].addr  <= wdata[AW-1:0];
                if (addr == BASE + OFS_AMASK) cfg[ch].amask <= wdata[AW-1:0];
                if (addr == BASE + OFS_TAG) begin
                    cfg[ch].asid     <= wdata[IW-1:0];
                    cfg[ch].asid_ign <= wdata[IW];
                end
                if (addr == BASE + OFS_CTRL) begin
                    cfg[ch].en       <= wdata[0];
                    cfg[ch].bus_sel  <= wdata[1];
                    cfg[ch].ctype    <= wdata[3:2];
                    cfg[ch].dir      <= wdata[5:4];
                    cfg[ch].size     <= wdata[7:6];
                    cfg[ch].after    <= wdata[8];
                    cfg[ch].dbus_sel <= (ch == 1) ? wdata[9] : 1'b0;
                end
                if (ch == 1 && addr == RG_BDATA)  cfg[ch].data  <= wdata[DW-1:0];
                if (ch == 1 && addr == RG_BDMASK) cfg[ch].dmask <= wdata[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_mode <= 1'b0;
            rep_n    <= '0;
        end else if (we && addr == RG_MODE) begin
            seq_mode <= wdata[0];
            rep_n    <= wdata[REP_W:1];
        end
    end

    assign stat_wr = we && (addr == RG_STAT);
    assign cond_wr = we && (addr != RG_STAT);
endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter bit HAS_DATA = 1'b0
) (
    input  cfg_t cfg,
    input  bus_t bus0,
    input  bus_t bus1,
    output logic hit,
    output logic is_fetch
);
    bus_t abus;
    logic addr_ok, tag_ok, qual_ok, data_ok;

    assign abus    = cfg.bus_sel ? bus1 : bus0;
    assign addr_ok = ((abus.addr ^ cfg.addr) & ~cfg.amask) == '0;
    assign tag_ok  = cfg.asid_ign || (abus.asid == cfg.asid);
    assign qual_ok = ctype_ok(cfg.ctype, abus.fetch)
                  && dir_ok(cfg.dir, abus.write)
                  && size_ok(cfg.size, abus.size);

    if (HAS_DATA) begin : g_data
        logic [DW-1:0] dval;
        assign dval    = cfg.dbus_sel ? bus1.data : bus0.data;
        assign data_ok = ((dval ^ cfg.data) & ~cfg.dmask) == '0;
    end else begin : g_nodata
        assign data_ok = 1'b1;
    end

    assign hit      = cfg.en && abus.valid && addr_ok && tag_ok && qual_ok && data_ok;
    assign is_fetch = abus.fetch;
endmodule

// File: rtl/brk_seq.sv
module brk_seq #(
    parameter int REP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_a,
    input  logic             hit_b,
    input  logic             fetch_a,
    input  logic             fetch_b,
    input  logic             after_a,
    input  logic             after_b,
    input  logic             seq_mode,
    input  logic [REP_W-1:0] rep_n,
    input  logic             cond_wr,
    input  logic             stat_wr,
    input  logic [1:0]       stat_keep,
    input  logic             ret_vld,
    output logic             armed,
    output logic [REP_W-1:0] rep_cnt,
    output logic             pend,
    output logic             fire_b,
    output logic             brk_req,
    output logic             stat_a,
    output logic             stat_b
);
    localparam int CW = REP_W + 1;

    logic          b_elig, fire_a, late_a, late_b, now_req, ret_fire;
    logic [CW-1:0] target;

    assign target   = (rep_n == '0) ? CW'(1) : {1'b0, rep_n};
    assign b_elig   = hit_b && (!seq_mode || armed);
    assign fire_b   = b_elig && (({1'b0, rep_cnt} + CW'(1)) == target);
    assign fire_a   = hit_a && !seq_mode;
    assign late_a   = fire_a && after_a && fetch_a;
    assign late_b   = fire_b && after_b && fetch_b;
    assign now_req  = (fire_a && !late_a) || (fire_b && !late_b);
    assign ret_fire = pend && ret_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            rep_cnt <= '0;
        end else if (cond_wr) begin
            armed   <= 1'b0;
            rep_cnt <= '0;
        end else begin
            if (fire_b)
                armed <= 1'b0;
            else if (seq_mode && hit_a)
                armed <= 1'b1;
            if (fire_b)
                rep_cnt <= '0;
            else if (b_elig)
                rep_cnt <= rep_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            brk_req <= 1'b0;
            stat_a  <= 1'b0;
            stat_b  <= 1'b0;
        end else begin
            pend    <= late_a || late_b || (pend && !ret_vld);
            brk_req <= now_req || ret_fire;
            stat_a  <= hit_a  || (stat_a && !(stat_wr && !stat_keep[0]));
            stat_b  <= fire_b || (stat_b && !(stat_wr && !stat_keep[1]));
        end
    end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int REP_W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          bus0_vld,
    input  logic [7:0]    bus0_asid,
    input  logic [31:0]   bus0_addr,
    input  logic [31:0]   bus0_data,
    input  logic          bus0_fetch,
    input  logic          bus0_wr,
    input  logic [1:0]    bus0_size,
    input  logic          bus1_vld,
    input  logic [7:0]    bus1_asid,
    input  logic [31:0]   bus1_addr,
    input  logic [31:0]   bus1_data,
    input  logic          bus1_fetch,
    input  logic          bus1_wr,
    input  logic [1:0]    bus1_size,
    input  logic          ret_vld,
    output logic          brk_req,
    output logic          stat_a,
    output logic          stat_b
);
    bus_t             bus0, bus1;
    cfg_t [NCH-1:0]   cfg;
    logic [NCH-1:0]   hit, is_fetch;
    logic             seq_mode, cond_wr, stat_wr, armed, pend, fire_b;
    logic [REP_W-1:0] rep_n, rep_cnt;

    assign bus0 = '{valid: bus0_vld, asid: bus0_asid, addr: bus0_addr, data: bus0_data,
                    fetch: bus0_fetch, write: bus0_wr, size: bus0_size};
    assign bus1 = '{valid: bus1_vld, asid: bus1_asid, addr: bus1_addr, data: bus1_data,
                    fetch: bus1_fetch, write: bus1_wr, size: bus1_size};

    brk_regs #(.REP_W(REP_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cfg(cfg), .seq_mode(seq_mode), .rep_n(rep_n),
        .cond_wr(cond_wr), .stat_wr(stat_wr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        brk_chan #(.HAS_DATA(ch == 1)) u_chan (
            .cfg(cfg[ch]), .bus0(bus0), .bus1(bus1),
            .hit(hit[ch]), .is_fetch(is_fetch[ch])
        );
    end

    brk_seq #(.REP_W(REP_W)) u_seq (
        .clk(clk), .rst(rst),
        .hit_a(hit[0]), .hit_b(hit[1]),
        .fetch_a(is_fetch[0]), .fetch_b(is_fetch[1]),
        .after_a(cfg[0].after), .after_b(cfg[1].after),
        .seq_mode(seq_mode), .rep_n(rep_n), .cond_wr(cond_wr),
        .stat_wr(stat_wr), .stat_keep(reg_wdata[1:0]), .ret_vld(ret_vld),
        .armed(armed), .rep_cnt(rep_cnt), .pend(pend), .fire_b(fire_b),
        .brk_req(brk_req), .stat_a(stat_a), .stat_b(stat_b)
    );
endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
    parameter int REP_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_a,
    input logic             hit_b,
    input logic             seq_mode,
    input logic             armed,
    input logic [REP_W-1:0] rep_cnt,
    input logic [REP_W-1:0] rep_n,
    input logic             pend,
    input logic             fire_b,
    input logic             ret_vld,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic             brk_req,
    input logic             stat_a,
    input logic             stat_b
);
    localparam logic [3:0] STAT_OFS = 4'd11;

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(hit_a || hit_b || (pend && ret_vld)));                        // R6
    AST_SEQ_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
        (seq_mode && !armed) |-> !fire_b);                                              // R7
    AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (rep_n == '0) ? (rep_cnt == '0) : (rep_cnt < rep_n));                           // R8
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !ret_vld) |=> pend);                                                   // R9
    AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_a && !(reg_we && reg_addr == STAT_OFS)) |=> stat_a);                      // R10
    AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_b && !(reg_we && reg_addr == STAT_OFS)) |=> stat_b);                      // R10
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != STAT_OFS) |=> (!armed && rep_cnt == '0));                 // R11
endmodule

bind brk_unit brk_chk #(.REP_W(REP_W)) i_brk_chk (
    .clk(clk), .rst(rst), .hit_a(hit[0]), .hit_b(hit[1]),
    .seq_mode(seq_mode), .armed(armed), .rep_cnt(rep_cnt), .rep_n(rep_n),
    .pend(pend), .fire_b(fire_b), .ret_vld(ret_vld),
    .reg_we(reg_we), .reg_addr(reg_addr),
    .brk_req(brk_req), .stat_a(stat_a), .stat_b(stat_b)
);

// File: tb/test_brk_unit.sv
module test_brk_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        b0_vld = 0, b0_fetch = 0, b0_wr = 0, b1_vld = 0, b1_fetch = 0, b1_wr = 0;
    logic [7:0]  b0_asid = 0, b1_asid = 0;
    logic [31:0] b0_addr = 0, b0_data = 0, b1_addr = 0, b1_data = 0;
    logic [1:0]  b0_size = 0, b1_size = 0;
    logic        ret_vld = 1'b0;
    logic        brk_req, stat_a, stat_b;
    int          nchk = 0;
    int          nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_unit i_brk_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .bus0_vld(b0_vld), .bus0_asid(b0_asid), .bus0_addr(b0_addr), .bus0_data(b0_data),
        .bus0_fetch(b0_fetch), .bus0_wr(b0_wr), .bus0_size(b0_size),
        .bus1_vld(b1_vld), .bus1_asid(b1_asid), .bus1_addr(b1_addr), .bus1_data(b1_data),
        .bus1_fetch(b1_fetch), .bus1_wr(b1_wr), .bus1_size(b1_size),
        .ret_vld(ret_vld), .brk_req(brk_req), .stat_a(stat_a), .stat_b(stat_b)
    );

    function automatic logic [31:0] ctl(input logic en, input logic bsel, input logic [1:0] ct,
                                        input logic [1:0] dr, input logic [1:0] sz,
                                        input logic after, input logic dsel);
        return {22'b0, dsel, after, sz, dr, ct, bsel, en};
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set0(input logic [7:0] t, input logic [31:0] a, input logic [31:0] d,
                        input logic f, input logic w, input logic [1:0] s);
        b0_asid = t; b0_addr = a; b0_data = d; b0_fetch = f; b0_wr = w; b0_size = s;
    endtask

    task automatic set1(input logic [7:0] t, input logic [31:0] a, input logic [31:0] d,
                        input logic f, input logic w, input logic [1:0] s);
        b1_asid = t; b1_addr = a; b1_data = d; b1_fetch = f; b1_wr = w; b1_size = s;
    endtask

    task automatic go(input logic use0, input logic use1);
        b0_vld = use0; b1_vld = use1;
        @(negedge clk);
        b0_vld = 1'b0; b1_vld = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state and disabled channels
        chk(brk_req, 1'b0, "R12 brk after reset");
        chk(stat_a, 1'b0, "R12 flag A after reset");
        chk(stat_b, 1'b0, "R12 flag B after reset");
        set0(8'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd2);
        go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R12 disabled channels");

        // R1: per-bit address mask, low 12 bits masked
        wr(4'd0, 32'h1234_5000); wr(4'd1, 32'h0000_0FFF); wr(4'd2, 32'h100);
        wr(4'd3, ctl(1, 0, 0, 0, 0, 0, 0));
        for (int k = 0; k < 32; k++) begin
            set0(8'h0, 32'h1234_5000 ^ (32'h1 << k), 32'h0, 1'b0, 1'b0, 2'd2);
            go(1'b1, 1'b0);
            chk(brk_req, k < 12, $sformatf("R1 addr bit %0d", k));
        end

        // R2: tag compare and tag ignore
        wr(4'd2, 32'h05A);
        set0(8'h5A, 32'h1234_5000, 32'h0, 1'b0, 1'b0, 2'd2); go(1'b1, 1'b0);
        chk(brk_req, 1'b1, "R2 tag equal");
        set0(8'h5B, 32'h1234_5000, 32'h0, 1'b0, 1'b0, 2'd2); go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R2 tag differs");
        wr(4'd2, 32'h15A);
        go(1'b1, 1'b0);
        chk(brk_req, 1'b1, "R2 tag ignored");

        // R3: port selection
        wr(4'd3, ctl(1, 1, 0, 0, 0, 0, 0));
        go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R3 other port ignored");
        set1(8'h0, 32'h1234_5000, 32'h0, 1'b0, 1'b0, 2'd2); go(1'b0, 1'b1);
        chk(brk_req, 1'b1, "R3 selected port");

        // R4: qualifier sweep
        for (int ct = 0; ct < 4; ct++)
            for (int dr = 0; dr < 4; dr++)
                for (int sz = 0; sz < 4; sz++) begin
                    wr(4'd3, ctl(1, 0, 2'(ct), 2'(dr), 2'(sz), 0, 0));
                    for (int f = 0; f < 2; f++)
                        for (int w = 0; w < 2; w++)
                            for (int bs = 0; bs < 3; bs++) begin
                                logic ok;
                                ok = (ct == 0 || ct == 3 || (ct == 1 && f == 1) || (ct == 2 && f == 0))
                                  && (dr == 0 || dr == 3 || (dr == 1 && w == 0) || (dr == 2 && w == 1))
                                  && (sz == 0 || sz == bs + 1);
                                set0(8'h0, 32'h1234_5000, 32'h0, f[0], w[0], 2'(bs));
                                go(1'b1, 1'b0);
                                chk(brk_req, ok, $sformatf("R4 ct%0d dr%0d sz%0d f%0d w%0d s%0d",
                                                           ct, dr, sz, f, w, bs));
                            end
                end

        // R5: channel B data compare with mask and data source
        wr(4'd3, 32'h0);
        wr(4'd4, 32'h0); wr(4'd5, 32'hFFFF_FFFF); wr(4'd6, 32'h100);
        wr(4'd8, 32'hCAFE_0000); wr(4'd9, 32'h0000_FFFF);
        wr(4'd7, ctl(1, 0, 0, 0, 0, 0, 0));
        for (int k = 0; k < 32; k++) begin
            set0(8'h0, 32'h0, 32'hCAFE_0000 ^ (32'h1 << k), 1'b0, 1'b0, 2'd2);
            go(1'b1, 1'b0);
            chk(brk_req, k < 16, $sformatf("R5 data bit %0d", k));
        end
        wr(4'd7, ctl(1, 0, 0, 0, 0, 0, 1));
        set0(8'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd2);
        set1(8'h0, 32'h0, 32'hCAFE_1234, 1'b0, 1'b0, 2'd2);
        go(1'b1, 1'b0);
        chk(brk_req, 1'b1, "R5 data from port 1");
        b1_data = 32'h0;
        go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R5 port 1 data mismatch");

        // R6: independent mode, one-cycle request and flags
        wr(4'd11, 32'h0);
        wr(4'd0, 32'h100); wr(4'd1, 32'h0); wr(4'd3, ctl(1, 0, 0, 0, 0, 0, 0));
        wr(4'd4, 32'h200); wr(4'd5, 32'h0); wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd7, ctl(1, 1, 0, 0, 0, 0, 0));
        set0(8'h0, 32'h100, 32'h0, 1'b0, 1'b0, 2'd2);
        set1(8'h0, 32'h200, 32'h0, 1'b0, 1'b0, 2'd2);
        go(1'b1, 1'b0);
        chk(brk_req, 1'b1, "R6 A request");
        chk(stat_a, 1'b1, "R6 flag A set");
        chk(stat_b, 1'b0, "R6 flag B clear");
        @(negedge clk);
        chk(brk_req, 1'b0, "R6 request lasts one cycle");
        go(1'b0, 1'b1);
        chk(brk_req, 1'b1, "R6 B request");
        chk(stat_b, 1'b1, "R6 flag B set");

        // R10: status clear by writing zero
        wr(4'd11, 32'h2);
        chk(stat_a, 1'b0, "R10 flag A cleared");
        chk(stat_b, 1'b1, "R10 flag B kept");
        wr(4'd11, 32'h0);
        chk(stat_b, 1'b0, "R10 flag B cleared");

        // R7: sequential mode
        wr(4'd10, 32'h1);
        go(1'b0, 1'b1);
        chk(brk_req, 1'b0, "R7 B before A");
        go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R7 A alone");
        go(1'b0, 1'b1);
        chk(brk_req, 1'b1, "R7 A then B");
        go(1'b0, 1'b1);
        chk(brk_req, 1'b0, "R7 sequence reset");
        go(1'b1, 1'b1);
        chk(brk_req, 1'b0, "R7 same cycle");
        go(1'b0, 1'b1);
        chk(brk_req, 1'b1, "R7 B after same-cycle A");

        // R11: rewrite clears A record
        go(1'b1, 1'b0);
        wr(4'd0, 32'h100);
        go(1'b0, 1'b1);
        chk(brk_req, 1'b0, "R11 record cleared");

        // R8: repeat count of three
        wr(4'd3, 32'h0);
        wr(4'd10, 32'h3 << 1);
        for (int n = 1; n <= 4; n++) begin
            go(1'b0, 1'b1);
            chk(brk_req, n == 3, $sformatf("R8 match %0d", n));
        end
        // R11: rewrite clears repeat count (count is 1 here)
        go(1'b0, 1'b1);
        wr(4'd10, 32'h3 << 1);
        for (int n = 1; n <= 3; n++) begin
            go(1'b0, 1'b1);
            chk(brk_req, n == 3, $sformatf("R11 match %0d after rewrite", n));
        end

        // R9: break after execution
        wr(4'd10, 32'h0); wr(4'd7, 32'h0);
        wr(4'd3, ctl(1, 0, 0, 0, 0, 1, 0));
        set0(8'h0, 32'h100, 32'h0, 1'b1, 1'b0, 2'd2);
        go(1'b1, 1'b0);
        chk(brk_req, 1'b0, "R9 held at fetch");
        @(negedge clk);
        chk(brk_req, 1'b0, "R9 held without strobe");
        ret_vld = 1'b1;
        @(negedge clk);
        ret_vld = 1'b0;
        chk(brk_req, 1'b1, "R9 released by strobe");
        @(negedge clk);
        chk(brk_req, 1'b0, "R9 single release");
        b0_fetch = 1'b0;
        go(1'b1, 1'b0);
        chk(brk_req, 1'b1, "R9 data access immediate");

        summary();
        $finish;
    end
endmodule